// File: doc/BRIEF.md
# Descriptor-Driven Address Sequencer

This block runs one transfer descriptor for a single channel. A descriptor holds a source and a destination start address, a signed per-beat offset for each side, a transfer-unit size code for each side, an inner byte count and an outer iteration count. It also holds two end-of-loop adjustments and a handful of control bits. The block turns this descriptor into a stream of beats for a plain memory read/write port. Each beat carries a source address, a destination address and the two size codes.

A trigger is either a software start pulse or a hardware request while requests are enabled. Each trigger runs one inner loop, which is a fixed number of beats. Once the outer count has been used up, the end adjustments are applied and `done` is raised. The iteration count then reloads, so the same descriptor can run again. Optional pulses mark completion and the half-way point. With chaining enabled, the destination adjustment field is treated as the address of the next descriptor, and the block asks for that descriptor to be loaded.

The beat output is a valid/ready stream. `beat_valid` stays high, and the beat fields stay unchanged, until `beat_ready` is seen high at a clock edge. The beat transfers on that edge. The consumer may hold `beat_ready` low for any number of cycles, and the sequencer does not advance while it does.

Top module: `desc_addr_seq`

## Requirements
- R1: Size codes map to unit bytes as follows: 0 is 1 B, 1 is 2 B, 2 is 4 B, 4 is 16 B and 5 is 32 B. A trigger on a descriptor that has code 3, 6 or 7 on either side sets `cfg_err` and starts nothing. `beat_src_size` and `beat_dst_size` carry the loaded codes.
- R2: A trigger also sets `cfg_err` instead of starting in three cases: the inner byte count is zero, the inner byte count is not a multiple of either side's unit size, or the outer count is zero. An accepted load clears `cfg_err`.
- R3: After each accepted beat, the source address advances by the sign-extended 16-bit source offset and the destination address advances by the destination offset. An offset of zero keeps that address fixed.
- R4: An accepted trigger runs exactly one inner loop of `inner_bytes >> src_size` beats. `active` is high from the cycle after the trigger until the cycle after the last beat is accepted.
- R5: The outer count is `{ld_iter_hi, ld_iter_lo}` (15 bits) when `ld_hi_is_link` is 0, and `ld_iter_lo` alone when it is 1. `iter_left` shows the remaining count and drops by one per finished inner loop.
- R6: On the final inner loop, the last beat adds the end adjustments together with the offsets: the source end adjustment to the source address, and the destination end adjustment to the destination address. In the same cycle `done` is set and `iter_left` reloads to the beginning count.
- R7: With chaining enabled, completion gives a one-cycle `sg_load_req` pulse, `sg_next_addr` equals the destination end field, and no destination adjustment is applied.
- R8: `req_en` is set by `req_en_set`. It is cleared at completion when the descriptor's drop-request bit is set, and the clear wins over a set in the same cycle.
- R9: With its enable bit set, `irq_major` pulses for one cycle at completion. With its enable bit set, `irq_half` pulses after an inner loop when the remaining count equals floor(beginning/2) and that value is nonzero.
- R10: While `active` is high, loads and triggers are ignored. A hardware request is ignored while `req_en` is 0. A trigger is ignored when no descriptor has been loaded, and in the same cycle as an accepted load.
- R11: While `beat_valid` is high and `beat_ready` is low, the beat fields stay stable.
- R12: After reset, all flags and `beat_valid` are 0. `done` is cleared by an accepted trigger or load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load the descriptor fields below |
| ld_src_addr | input | AW | Source start address |
| ld_dst_addr | input | AW | Destination start address |
| ld_src_off | input | 16 | Signed source per-beat offset |
| ld_dst_off | input | 16 | Signed destination per-beat offset |
| ld_src_size | input | 3 | Source unit size code |
| ld_dst_size | input | 3 | Destination unit size code |
| ld_inner_bytes | input | NB_W | Bytes per inner loop |
| ld_src_last | input | AW | Source end adjustment |
| ld_dst_last | input | AW | Destination end adjustment or next descriptor address |
| ld_iter_lo | input | 9 | Outer count, low bits |
| ld_iter_hi | input | 6 | Outer count, high bits, or link field |
| ld_hi_is_link | input | 1 | High field is a link field, not count bits |
| ld_chain_en | input | 1 | Chain to the next descriptor at completion |
| ld_drop_req | input | 1 | Clear request enable at completion |
| ld_half_irq_en | input | 1 | Enable half-way pulse |
| ld_major_irq_en | input | 1 | Enable completion pulse |
| sw_start | input | 1 | Software trigger |
| hw_req | input | 1 | Hardware request |
| req_en_set | input | 1 | Set request enable |
| req_en | output | 1 | Hardware request enable |
| beat_valid | output | 1 | Beat available |
| beat_ready | input | 1 | Consumer accepts the beat |
| beat_src | output | AW | Beat source address |
| beat_dst | output | AW | Beat destination address |
| beat_src_size | output | 3 | Source size code |
| beat_dst_size | output | 3 | Destination size code |
| active | output | 1 | Inner loop in progress |
| done | output | 1 | Outer loop finished |
| irq_major | output | 1 | Completion pulse |
| irq_half | output | 1 | Half-way pulse |
| cfg_err | output | 1 | Trigger refused because the descriptor is invalid |
| sg_load_req | output | 1 | Request to load the next descriptor |
| sg_next_addr | output | AW | Next descriptor address |
| iter_left | output | 15 | Remaining outer count |

## Verification
A wrong address register shows up on `beat_src` or `beat_dst` at the very next beat, and it stays wrong for the rest of the descriptor. A wrong beat counter shows up within one inner loop, as `active` falling early or late. A wrong outer counter shows up on `iter_left` right after the inner loop in which it went wrong. It also moves the cycle of `done`, `irq_half` and the end-adjusted addresses that can be seen once `active` drops. Sweeps over every valid size pair, positive, negative and zero offsets, and several outer counts, including a 15-bit count, compare each of these values cycle by cycle against arithmetic computed in the bench.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  localparam int OFF_W  = 16;
  localparam int SZ_W   = 3;
  localparam int ITLO_W = 9;
  localparam int LNK_W  = 6;
  localparam int IT_W   = ITLO_W + LNK_W;

  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} run_state_t;

  // Legal unit size codes; the code is also log2 of the unit in bytes.
  function automatic logic size_code_ok(input logic [SZ_W-1:0] c);
    return (c == 3'd0) || (c == 3'd1) || (c == 3'd2) || (c == 3'd4) || (c == 3'd5);
  endfunction
endpackage

// File: rtl/dseq_cfg_chk.sv
module dseq_cfg_chk
  import dseq_pkg::*;
#(
  parameter int NB_W = 16
) (
  input  logic [SZ_W-1:0] ssize,
  input  logic [SZ_W-1:0] dsize,
  input  logic [NB_W-1:0] nbytes,
  input  logic [IT_W-1:0] iters,
  output logic            bad,
  output logic [NB_W-1:0] beats
);
  logic [NB_W-1:0] smask, dmask;

  always_comb begin
    smask = (NB_W'(1) << ssize) - NB_W'(1);
    dmask = (NB_W'(1) << dsize) - NB_W'(1);
    bad   = !size_code_ok(ssize) || !size_code_ok(dsize) ||
            (nbytes == '0) || ((nbytes & smask) != '0) ||
            ((nbytes & dmask) != '0) || (iters == '0);
    beats = nbytes >> ssize;
  end
endmodule

// File: rtl/dseq_addr_unit.sv
module dseq_addr_unit #(
  parameter int AW    = 32,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    load_addr,
  input  logic             step,
  input  logic [OFF_W-1:0] offset,
  input  logic             adj_en,
  input  logic [AW-1:0]    adj,
  output logic [AW-1:0]    addr
);
  logic [AW-1:0] off_ext, inc;

  // End adjustment rides on the same adder as the final beat offset.
  assign off_ext = {{(AW-OFF_W){offset[OFF_W-1]}}, offset};
  assign inc     = off_ext + (adj_en ? adj : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_addr;
    else if (step) addr <= addr + inc;
  end
endmodule

// File: rtl/dseq_iter.sv
module dseq_iter #(
  parameter int IT_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IT_W-1:0] load_val,
  input  logic            dec,
  output logic [IT_W-1:0] cur,
  output logic            major_hit,
  output logic            half_hit
);
  logic [IT_W-1:0] begin_q, half_pt;

  assign half_pt   = begin_q >> 1;
  assign major_hit = dec && (cur == IT_W'(1));
  assign half_hit  = dec && (half_pt != '0) && ((cur - IT_W'(1)) == half_pt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      begin_q <= '0;
      cur     <= '0;
    end else if (load) begin
      begin_q <= load_val;
      cur     <= load_val;
    end else if (dec) begin
      cur <= major_hit ? begin_q : cur - IT_W'(1);
    end
  end
endmodule

// File: rtl/desc_addr_seq.sv
module desc_addr_seq
  import dseq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NB_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [AW-1:0]     ld_src_addr,
  input  logic [AW-1:0]     ld_dst_addr,
  input  logic [OFF_W-1:0]  ld_src_off,
  input  logic [OFF_W-1:0]  ld_dst_off,
  input  logic [SZ_W-1:0]   ld_src_size,
  input  logic [SZ_W-1:0]   ld_dst_size,
  input  logic [NB_W-1:0]   ld_inner_bytes,
  input  logic [AW-1:0]     ld_src_last,
  input  logic [AW-1:0]     ld_dst_last,
  input  logic [ITLO_W-1:0] ld_iter_lo,
  input  logic [LNK_W-1:0]  ld_iter_hi,
  input  logic              ld_hi_is_link,
  input  logic              ld_chain_en,
  input  logic              ld_drop_req,
  input  logic              ld_half_irq_en,
  input  logic              ld_major_irq_en,
  input  logic              sw_start,
  input  logic              hw_req,
  input  logic              req_en_set,
  output logic              req_en,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [AW-1:0]     beat_src,
  output logic [AW-1:0]     beat_dst,
  output logic [SZ_W-1:0]   beat_src_size,
  output logic [SZ_W-1:0]   beat_dst_size,
  output logic              active,
  output logic              done,
  output logic              irq_major,
  output logic              irq_half,
  output logic              cfg_err,
  output logic              sg_load_req,
  output logic [AW-1:0]     sg_next_addr,
  output logic [IT_W-1:0]   iter_left
);
  localparam int SIDES = 2;

  run_state_t       state_q;
  logic             loaded_q;
  logic [NB_W-1:0]  beats_q;
  logic [SZ_W-1:0]  ssize_q, dsize_q;
  logic [OFF_W-1:0] soff_q, doff_q;
  logic [NB_W-1:0]  nbytes_q;
  logic [AW-1:0]    slast_q, dlast_q;
  logic             chain_q, drop_q, hirq_q, mirq_q;
  logic             req_en_q, done_q, cfg_err_q;
  logic             irq_major_q, irq_half_q, sg_req_q;

  logic             ld_acc, trig, go, err_evt, fire, minor_end;
  logic             major_hit, half_hit, cfg_bad;
  logic [NB_W-1:0]  beats_calc;
  logic [IT_W-1:0]  eff_iters;

  logic [SIDES-1:0][AW-1:0]    au_base, au_adj, au_addr;
  logic [SIDES-1:0][OFF_W-1:0] au_off;
  logic [SIDES-1:0]            au_adj_en;

  // Outer count: high field is count bits unless it names a link target.
  assign eff_iters = ld_hi_is_link ? IT_W'(ld_iter_lo) : {ld_iter_hi, ld_iter_lo};

  assign ld_acc    = ld_valid && (state_q == S_IDLE);
  assign trig      = (sw_start || (hw_req && req_en_q)) && loaded_q &&
                     (state_q == S_IDLE) && !ld_valid;
  assign go        = trig && !cfg_bad;
  assign err_evt   = trig && cfg_bad;
  assign fire      = (state_q == S_RUN) && beat_ready;
  assign minor_end = fire && (beats_q == NB_W'(1));

  dseq_cfg_chk #(.NB_W(NB_W)) u_cfg (
    .ssize (ssize_q),
    .dsize (dsize_q),
    .nbytes(nbytes_q),
    .iters (iter_left),
    .bad   (cfg_bad),
    .beats (beats_calc)
  );

  dseq_iter #(.IT_W(IT_W)) u_iter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld_acc),
    .load_val (eff_iters),
    .dec      (minor_end),
    .cur      (iter_left),
    .major_hit(major_hit),
    .half_hit (half_hit)
  );

  always_comb begin
    au_base[0]   = ld_src_addr;
    au_base[1]   = ld_dst_addr;
    au_off[0]    = soff_q;
    au_off[1]    = doff_q;
    au_adj[0]    = slast_q;
    au_adj[1]    = dlast_q;
    au_adj_en[0] = major_hit;
    au_adj_en[1] = major_hit && !chain_q;
  end

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    dseq_addr_unit #(.AW(AW), .OFF_W(OFF_W)) u_au (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_acc),
      .load_addr(au_base[g]),
      .step     (fire),
      .offset   (au_off[g]),
      .adj_en   (au_adj_en[g]),
      .adj      (au_adj[g]),
      .addr     (au_addr[g])
    );
  end

  // Descriptor fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      ssize_q  <= '0;
      dsize_q  <= '0;
      soff_q   <= '0;
      doff_q   <= '0;
      nbytes_q <= '0;
      slast_q  <= '0;
      dlast_q  <= '0;
      chain_q  <= 1'b0;
      drop_q   <= 1'b0;
      hirq_q   <= 1'b0;
      mirq_q   <= 1'b0;
    end else if (ld_acc) begin
      loaded_q <= 1'b1;
      ssize_q  <= ld_src_size;
      dsize_q  <= ld_dst_size;
      soff_q   <= ld_src_off;
      doff_q   <= ld_dst_off;
      nbytes_q <= ld_inner_bytes;
      slast_q  <= ld_src_last;
      dlast_q  <= ld_dst_last;
      chain_q  <= ld_chain_en;
      drop_q   <= ld_drop_req;
      hirq_q   <= ld_half_irq_en;
      mirq_q   <= ld_major_irq_en;
    end
  end

  // Run control and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      beats_q     <= '0;
      done_q      <= 1'b0;
      cfg_err_q   <= 1'b0;
      req_en_q    <= 1'b0;
      irq_major_q <= 1'b0;
      irq_half_q  <= 1'b0;
      sg_req_q    <= 1'b0;
    end else begin
      irq_major_q <= major_hit && mirq_q;
      irq_half_q  <= half_hit && hirq_q;
      sg_req_q    <= major_hit && chain_q;

      if (go) begin
        state_q <= S_RUN;
        beats_q <= beats_calc;
      end else if (fire) begin
        beats_q <= beats_q - NB_W'(1);
        if (minor_end) state_q <= S_IDLE;
      end

      if (go || ld_acc)   done_q <= 1'b0;
      else if (major_hit) done_q <= 1'b1;

      if (ld_acc)       cfg_err_q <= 1'b0;
      else if (err_evt) cfg_err_q <= 1'b1;

      if (major_hit && drop_q) req_en_q <= 1'b0;
      else if (req_en_set)     req_en_q <= 1'b1;
    end
  end

  assign active        = (state_q == S_RUN);
  assign beat_valid    = (state_q == S_RUN);
  assign beat_src      = au_addr[0];
  assign beat_dst      = au_addr[1];
  assign beat_src_size = ssize_q;
  assign beat_dst_size = dsize_q;
  assign done          = done_q;
  assign cfg_err       = cfg_err_q;
  assign req_en        = req_en_q;
  assign irq_major     = irq_major_q;
  assign irq_half      = irq_half_q;
  assign sg_load_req   = sg_req_q;
  assign sg_next_addr  = dlast_q;
endmodule

// File: rtl/dseq_chk.sv
module dseq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          done,
  input logic          beat_valid,
  input logic          beat_ready,
  input logic [AW-1:0] beat_src,
  input logic [AW-1:0] beat_dst,
  input logic [2:0]    beat_src_size,
  input logic [2:0]    beat_dst_size,
  input logic          irq_major,
  input logic          irq_half,
  input logic          sg_load_req,
  input logic          cfg_err,
  input logic          req_en
);
  // R11
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_src) && $stable(beat_dst) &&
    $stable(beat_src_size) && $stable(beat_dst_size));
  // R12
  run_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !done);
  // R9
  major_irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_major |-> done);
  // R9
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_half |-> !irq_major);
  // R7
  chain_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sg_load_req |-> done);
  // R2
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !active);
  // R6
  done_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(active) && !active);
  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_en) |-> done);
endmodule

bind desc_addr_seq dseq_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .active       (active),
  .done         (done),
  .beat_valid   (beat_valid),
  .beat_ready   (beat_ready),
  .beat_src     (beat_src),
  .beat_dst     (beat_dst),
  .beat_src_size(beat_src_size),
  .beat_dst_size(beat_dst_size),
  .irq_major    (irq_major),
  .irq_half     (irq_half),
  .sg_load_req  (sg_load_req),
  .cfg_err      (cfg_err),
  .req_en       (req_en)
);

// File: tb/desc_addr_seq_test.sv
module desc_addr_seq_test;
  localparam int AW   = 32;
  localparam int NB_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic ld_valid;
  logic [AW-1:0] ld_src_addr, ld_dst_addr, ld_src_last, ld_dst_last;
  logic [15:0] ld_src_off, ld_dst_off;
  logic [2:0] ld_src_size, ld_dst_size;
  logic [NB_W-1:0] ld_inner_bytes;
  logic [8:0] ld_iter_lo;
  logic [5:0] ld_iter_hi;
  logic ld_hi_is_link, ld_chain_en, ld_drop_req, ld_half_irq_en, ld_major_irq_en;
  logic sw_start, hw_req, req_en_set, req_en;
  logic beat_valid, beat_ready;
  logic [AW-1:0] beat_src, beat_dst, sg_next_addr;
  logic [2:0] beat_src_size, beat_dst_size;
  logic active, done, irq_major, irq_half, cfg_err, sg_load_req;
  logic [14:0] iter_left;

  desc_addr_seq #(.AW(AW), .NB_W(NB_W)) uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid),
    .ld_src_addr(ld_src_addr), .ld_dst_addr(ld_dst_addr),
    .ld_src_off(ld_src_off), .ld_dst_off(ld_dst_off),
    .ld_src_size(ld_src_size), .ld_dst_size(ld_dst_size),
    .ld_inner_bytes(ld_inner_bytes), .ld_src_last(ld_src_last), .ld_dst_last(ld_dst_last),
    .ld_iter_lo(ld_iter_lo), .ld_iter_hi(ld_iter_hi), .ld_hi_is_link(ld_hi_is_link),
    .ld_chain_en(ld_chain_en), .ld_drop_req(ld_drop_req),
    .ld_half_irq_en(ld_half_irq_en), .ld_major_irq_en(ld_major_irq_en),
    .sw_start(sw_start), .hw_req(hw_req), .req_en_set(req_en_set), .req_en(req_en),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_src(beat_src), .beat_dst(beat_dst),
    .beat_src_size(beat_src_size), .beat_dst_size(beat_dst_size),
    .active(active), .done(done), .irq_major(irq_major), .irq_half(irq_half),
    .cfg_err(cfg_err), .sg_load_req(sg_load_req), .sg_next_addr(sg_next_addr),
    .iter_left(iter_left)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [31:0] e_src, e_dst, m_sl, m_dl;
  int m_soff, m_doff, m_beats, m_biter, m_iter;
  bit m_sg, m_dr, m_ih, m_im, m_req_en;
  logic [2:0] m_ss, m_ds;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  task automatic set_desc(input logic [2:0] ss, input logic [2:0] ds, input int nb,
                          input int so, input int dof, input int lo, input int hi,
                          input bit lnk, input bit sg, input bit dr, input bit ih, input bit im);
    ld_src_size = ss; ld_dst_size = ds; ld_inner_bytes = NB_W'(nb);
    ld_src_off = 16'(so); ld_dst_off = 16'(dof);
    ld_iter_lo = 9'(lo); ld_iter_hi = 6'(hi); ld_hi_is_link = lnk;
    ld_chain_en = sg; ld_drop_req = dr; ld_half_irq_en = ih; ld_major_irq_en = im;
  endtask

  task automatic do_load(input bit with_start);
    ld_valid = 1'b1;
    sw_start = with_start;
    tick();
    ld_valid = 1'b0;
    sw_start = 1'b0;
    e_src = ld_src_addr; e_dst = ld_dst_addr;
    m_sl = ld_src_last; m_dl = ld_dst_last;
    m_soff = int'($signed(ld_src_off)); m_doff = int'($signed(ld_dst_off));
    m_ss = ld_src_size; m_ds = ld_dst_size;
    m_beats = int'(ld_inner_bytes) >> ld_src_size;
    m_biter = ld_hi_is_link ? int'(ld_iter_lo) : (int'(ld_iter_hi) * 512 + int'(ld_iter_lo));
    m_iter = m_biter;
    m_sg = ld_chain_en; m_dr = ld_drop_req; m_ih = ld_half_irq_en; m_im = ld_major_irq_en;
    chk(iter_left == 15'(m_biter), "R5 iter_left after load", iter_left, m_biter);
    chk(done == 1'b0, "R12 done cleared by load", done, 0);
    chk(cfg_err == 1'b0, "R2 cfg_err cleared by load", cfg_err, 0);
  endtask

  task automatic err_trigger(input string tag);
    do_load(1'b0);
    sw_start = 1'b1;
    tick();
    sw_start = 1'b0;
    chk(cfg_err == 1'b1, tag, cfg_err, 1);
    chk(active == 1'b0, tag, active, 0);
  endtask

  task automatic run_minor(input bit use_hw, input bit poke);
    int k, guard, rem, half;
    bit rdy, poked, poke_now, last, exp_half;
    logic [31:0] saved;
    if (use_hw) hw_req = 1'b1; else sw_start = 1'b1;
    tick();
    hw_req = 1'b0; sw_start = 1'b0;
    chk(active == 1'b1, "R4 active after trigger", active, 1);
    chk(done == 1'b0, "R12 done cleared by start", done, 0);
    k = 0; guard = 0; poked = 0;
    saved = '0;
    while (k < m_beats && guard < 2000) begin
      guard++;
      chk(beat_valid == 1'b1, "R4 beat_valid during loop", beat_valid, 1);
      if (!beat_valid) break;
      chk(beat_src == e_src, "R3 beat_src", beat_src, e_src);
      chk(beat_dst == e_dst, "R3 beat_dst", beat_dst, e_dst);
      chk(beat_src_size == m_ss && beat_dst_size == m_ds, "R1 beat size codes",
          {beat_src_size, beat_dst_size}, {m_ss, m_ds});
      rdy = (cyc % 4) != 3;
      beat_ready = rdy;
      poke_now = 0;
      if (poke && !poked && k == 1) begin
        poked = 1; poke_now = 1;
        ld_valid = 1'b1; sw_start = 1'b1; hw_req = 1'b1;
        saved = ld_src_addr; ld_src_addr = 32'hDEAD_0000;
      end
      tick();
      beat_ready = 1'b0;
      if (poke_now) begin
        ld_valid = 1'b0; sw_start = 1'b0; hw_req = 1'b0; ld_src_addr = saved;
      end
      if (rdy) begin
        k++;
        e_src = e_src + 32'(m_soff);
        e_dst = e_dst + 32'(m_doff);
      end
    end
    rem = m_iter - 1;
    last = (rem == 0);
    half = m_biter / 2;
    exp_half = m_ih && half != 0 && rem == half;
    if (last) begin
      e_src = e_src + m_sl;
      if (!m_sg) e_dst = e_dst + m_dl;
      m_iter = m_biter;
      if (m_dr) m_req_en = 0;
    end else begin
      m_iter = rem;
    end
    chk(active == 1'b0 && beat_valid == 1'b0, "R4 active low after loop", active, 0);
    chk(done == last, "R6 done at completion", done, last);
    chk(iter_left == 15'(m_iter), "R5 iter_left per loop", iter_left, m_iter);
    chk(irq_major == (last && m_im), "R9 irq_major", irq_major, last && m_im);
    chk(irq_half == exp_half, "R9 irq_half", irq_half, exp_half);
    chk(sg_load_req == (last && m_sg), "R7 sg_load_req", sg_load_req, last && m_sg);
    if (last && m_sg) chk(sg_next_addr == m_dl, "R7 sg_next_addr", sg_next_addr, m_dl);
    chk(beat_src == e_src, "R6 src after loop", beat_src, e_src);
    chk(beat_dst == e_dst, "R6 dst after loop", beat_dst, e_dst);
    chk(req_en == m_req_en, "R8 req_en", req_en, m_req_en);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int codes[5];
    codes = '{0, 1, 2, 4, 5};
    rst_n = 1'b0; ld_valid = 0; sw_start = 0; hw_req = 0; req_en_set = 0; beat_ready = 0;
    ld_src_addr = '0; ld_dst_addr = '0; ld_src_last = '0; ld_dst_last = '0;
    set_desc(3'd0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    m_req_en = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R12 reset state
    chk(active == 0 && done == 0 && beat_valid == 0, "R12 reset run flags", {active, done, beat_valid}, 0);
    chk(req_en == 0 && cfg_err == 0, "R12 reset req_en/cfg_err", {req_en, cfg_err}, 0);
    chk(irq_major == 0 && irq_half == 0 && sg_load_req == 0, "R12 reset pulses",
        {irq_major, irq_half, sg_load_req}, 0);

    // R10 trigger with nothing loaded
    sw_start = 1'b1; tick(); sw_start = 1'b0;
    chk(active == 0 && cfg_err == 0, "R10 trigger without descriptor", {active, cfg_err}, 0);

    // R1 illegal size codes
    ld_src_addr = 32'h100; ld_dst_addr = 32'h200;
    set_desc(3'd3, 3'd0, 8, 1, 1, 1, 0, 1, 0, 0, 0, 0); err_trigger("R1 src code 3");
    set_desc(3'd6, 3'd0, 8, 1, 1, 1, 0, 1, 0, 0, 0, 0); err_trigger("R1 src code 6");
    set_desc(3'd0, 3'd7, 8, 1, 1, 1, 0, 1, 0, 0, 0, 0); err_trigger("R1 dst code 7");
    set_desc(3'd0, 3'd3, 8, 1, 1, 1, 0, 1, 0, 0, 0, 0); err_trigger("R1 dst code 3");
    // R2 count errors
    set_desc(3'd2, 3'd2, 6, 4, 4, 1, 0, 1, 0, 0, 0, 0); err_trigger("R2 bytes not multiple of src");
    set_desc(3'd0, 3'd2, 2, 1, 4, 1, 0, 1, 0, 0, 0, 0); err_trigger("R2 bytes not multiple of dst");
    set_desc(3'd0, 3'd0, 0, 1, 1, 1, 0, 1, 0, 0, 0, 0); err_trigger("R2 zero bytes");
    set_desc(3'd0, 3'd0, 4, 1, 1, 0, 0, 0, 0, 0, 0, 0); err_trigger("R2 zero iterations");
    set_desc(3'd0, 3'd0, 4, 1, 1, 0, 5, 1, 0, 0, 0, 0); err_trigger("R5 link field not counted R2");

    // R10 trigger in the same cycle as a load
    set_desc(3'd2, 3'd2, 16, 4, 4, 2, 0, 1, 0, 0, 1, 1);
    do_load(1'b1);
    chk(active == 0, "R10 trigger with load ignored", active, 0);

    // Sweep: size pairs, offset signs, inner counts, outer counts
    for (int ci = 0; ci < 5; ci++) begin
      for (int nbm = 1; nbm <= 3; nbm++) begin
        for (int ov = 0; ov < 3; ov++) begin
          for (int it = 1; it <= 3; it++) begin
            int ss, ds, unit, nb, so, dof;
            ss = codes[ci];
            ds = codes[(ci + ov) % 5];
            unit = (ss > ds) ? (1 << ss) : (1 << ds);
            nb = nbm * unit;
            so = (ov == 1) ? -(1 << ss) : (1 << ss);
            dof = (ov == 2) ? 0 : (1 << ds);
            ld_src_addr = 32'h0001_0000 * (ci + 1) + 32'(nbm * 64);
            ld_dst_addr = 32'h8000_0000 + 32'h0000_1000 * 32'(it);
            ld_src_last = 32'hFFFF_FF00;
            ld_dst_last = 32'h0000_0400 + 32'(ov * 32);
            // R5: when ov==0 the high field carries 3 but is a link field
            set_desc(3'(ss), 3'(ds), nb, so, dof, it, (ov == 0) ? 3 : 0, (ov == 0),
                     (it == 2), 1'b0, 1'b1, (ov != 1));
            do_load(1'b0);
            for (int m = 0; m < it; m++) run_minor(1'b0, (m == 0) && (m_beats >= 3));
          end
        end
      end
    end

    // R8 / R10 hardware requests and request enable
    ld_src_addr = 32'h4000; ld_dst_addr = 32'h5000;
    ld_src_last = 32'h10; ld_dst_last = 32'h20;
    set_desc(3'd2, 3'd2, 8, 4, 4, 2, 0, 1, 0, 1, 1, 1);
    do_load(1'b0);
    hw_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(active == 0, "R10 hw_req without req_en ignored", active, 0);
    end
    hw_req = 1'b0;
    req_en_set = 1'b1; tick(); req_en_set = 1'b0;
    m_req_en = 1;
    chk(req_en == 1, "R8 req_en set", req_en, 1);
    run_minor(1'b1, 1'b0);
    run_minor(1'b1, 1'b0);
    chk(req_en == 0, "R8 req_en dropped at completion", req_en, 0);
    hw_req = 1'b1; tick(); hw_req = 1'b0;
    chk(active == 0, "R10 hw_req after drop ignored", active, 0);

    // R5 15-bit outer count: {2, 5} = 1029 loops
    ld_src_addr = 32'h7000; ld_dst_addr = 32'h9000;
    ld_src_last = 32'hFFFF_FBFB; ld_dst_last = 32'h0;
    set_desc(3'd0, 3'd0, 1, 1, -1, 5, 2, 0, 0, 0, 1, 1);
    do_load(1'b0);
    chk(iter_left == 15'd1029, "R5 wide count", iter_left, 1029);
    for (int m = 0; m < 1029; m++) run_minor(1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule